// File: doc/BRIEF.md
# NAND Flash Command and Address Sequencer

This block turns one command descriptor into the complete bus sequence for an 8-bit raw NAND flash device. A host loads the descriptor and its address and length inputs while the block is idle, then pulses a valid strobe. The descriptor carries:

- the opening command byte;
- an optional confirm byte with its own enable;
- a code for the number of address cycles;
- a data-phase enable and a direction bit;
- a flag that appends a status poll.

The block drives chip enable, the command and address latch enables, and the write and read strobes. Each bus cycle takes two clocks: the strobe is low in the first clock and high in the second. A write cycle drives the byte for both clocks. A read cycle captures the flash byte on the clock edge that ends the low half. Once the command and address phase is over, the block waits a fixed settle time. It then waits for the ready/busy line to go high. Page bytes move between the flash and a local byte buffer, which the host can also read and write. A one-cycle done pulse closes the operation.

Every common flash operation is one descriptor, or two in a row:

| Operation | Descriptor contents |
|---|---|
| Page read (large page) | 0x00, five address cycles, confirm 0x30, read phase |
| Page read (small page) | 0x00, five address cycles, no confirm, read phase |
| Program, first descriptor | 0x80, five address cycles, write phase |
| Program, second descriptor | 0x10 with no address cycles, status poll |
| Block erase | 0x60, three address cycles, confirm 0xD0 |
| Read ID | 0x90, one address cycle, four-byte read |
| Reset | 0xFF, no address cycles |

Within one descriptor, bytes written from the buffer go out before the confirm byte. Bytes read into the buffer are taken only after ready/busy has returned high.

Top module: `nand_seq`

## Requirements
- R1: After reset, and whenever `busy` is low, the bus is quiet: `nd_ce_n`=1, `nd_cle`=0, `nd_ale`=0, `nd_we_n`=1, `nd_re_n`=1 and `nd_dq_oe`=0. `done` is 0 in this state.
- R2: The descriptor layout is as follows.
  - Bit 0 is the direction: 1 means buffer to flash.
  - Bit 1 enables the data phase.
  - Bits 9:2 hold the opening command byte.
  - Bits 17:10 hold the confirm byte.
  - Bit 18 enables the confirm byte.
  - Bits 20:19 hold the address-cycle code.
  - Bit 21 requests a status poll.

  A command byte is sent with `nd_cle`=1 and `nd_dq_oe`=1, with `nd_we_n` low for one clock and then high for one clock. The data stays unchanged across both clocks. The confirm byte is sent only when bit 18 is 1.
- R3: The address-cycle code is decoded as 0→none, 1→one, 2→three, 3→five cycles. Each address cycle is sent with `nd_ale`=1.
  - In five-cycle mode, the first byte is `addr_lo` and the next four are the bytes of `addr_row`, lowest byte first.
  - In one-cycle and three-cycle modes, the bytes come from `addr_row` only, lowest byte first.
- R4: The order inside one operation is fixed:
  1. the opening command;
  2. the address cycles;
  3. the write data;
  4. the confirm byte;
  5. the settle and ready/busy wait;
  6. the read data;
  7. the status poll.
- R5: When the data phase is enabled and the direction is buffer to flash, buffer bytes 0 to `xfer_len`-1 are written to the flash in ascending order.
- R6: When the data phase is enabled and the direction is flash to buffer, `xfer_len` bytes are read after ready/busy is high. They are stored at buffer addresses 0 upward, so four ID bytes land with the first byte lowest.
- R7: With the data-phase enable cleared, no data strobe is issued and the buffer is left unchanged, whatever `xfer_len` is.
- R8: After the command and address phase, the block waits `SETTLE_CYC` clocks. It then holds with no strobe until `nd_rb` is 1, so an operation outlasts the device's busy time.
- R9: The status poll sends command 0x70 with no address cycle and reads one byte into `stat_byte`. `stat_ok` is 1 only when bit 6 of that byte is 1 and bit 0 is 0.
- R10: A descriptor is accepted only while `busy` is low. A `desc_valid` pulse while busy has no effect. `busy` stays high from acceptance until `done`, and `done` is high for exactly one clock.
- R11: `nd_cle` and `nd_ale` are never both 1, and `nd_we_n` and `nd_re_n` are never both 0.

### State machine
The controller has eleven states:

| State | Action | Next state |
|---|---|---|
| IDLE | Waits for a descriptor | CMD1 on accept |
| CMD1 | Sends the opening command | ADDR, or the next enabled phase when no address cycles are set |
| ADDR | Sends one address byte per bus cycle | The next enabled phase after the last byte |
| WDATA | Writes `xfer_len` buffer bytes | CMD2 if the confirm byte is enabled, otherwise SETTLE |
| CMD2 | Sends the confirm byte | SETTLE |
| SETTLE | Counts `SETTLE_CYC` clocks | WAIT |
| WAIT | Holds until ready/busy is high | RDATA if a read phase is set, otherwise the next enabled phase |
| RDATA | Reads `xfer_len` bytes into the buffer | STCMD if a status poll is set, otherwise DONE |
| STCMD | Sends 0x70 | STREAD |
| STREAD | Reads the status byte | DONE |
| DONE | Pulses `done` | IDLE |

Every skipped phase is bypassed combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| desc_valid | input | 1 | Descriptor strobe, taken only when idle |
| desc_word | input | 22 | Command descriptor (layout in R2) |
| xfer_len | input | $clog2(BUF_DEPTH)+1 | Data-phase length in bytes |
| addr_lo | input | 8 | First address byte in five-cycle mode |
| addr_row | input | 32 | Packed address bytes, lowest sent first |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock completion pulse |
| stat_byte | output | 8 | Last status byte read |
| stat_ok | output | 1 | Last status poll showed ready and no failure |
| hst_we | input | 1 | Host buffer write enable |
| hst_addr | input | $clog2(BUF_DEPTH) | Host buffer address |
| hst_wdata | input | 8 | Host buffer write data |
| hst_rdata | output | 8 | Host buffer read data (combinational) |
| nd_ce_n | output | 1 | Flash chip enable, active low |
| nd_cle | output | 1 | Command latch enable |
| nd_ale | output | 1 | Address latch enable |
| nd_we_n | output | 1 | Write strobe, active low |
| nd_re_n | output | 1 | Read strobe, active low |
| nd_dq_o | output | 8 | Data bus out |
| nd_dq_oe | output | 1 | Data bus output enable |
| nd_dq_i | input | 8 | Data bus in |
| nd_rb | input | 1 | Ready/busy line, 1 = ready |

## Verification
Several properties hold on every clock and are checked by assertions:
- the latch enables are mutually exclusive, and so are the two strobes;
- the bus is quiet whenever the block is idle;
- the data bus holds steady across each write strobe;
- no strobe toggles while ready/busy is low;
- `busy` persists until the single-cycle `done` pulse.

The directed scenarios cover what depends on the sequence of an operation:
- the exact byte order of each operation;
- the address-cycle selection from the code;
- buffer contents after reads and writes;
- the suppression of a disabled confirm byte or data phase;
- the status decode;
- the dropping of a descriptor offered while busy.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CMD1,
        ST_ADDR,
        ST_WDATA,
        ST_CMD2,
        ST_SETTLE,
        ST_WAIT,
        ST_RDATA,
        ST_STCMD,
        ST_STREAD,
        ST_DONE
    } seq_state_e;

    // descriptor: MSB first
    typedef struct packed {
        logic       stat_chk;   // 21
        logic [1:0] acyc;       // 20:19
        logic       cmd2_en;    // 18
        logic [7:0] cmd2;       // 17:10
        logic [7:0] cmd1;       // 9:2
        logic       data_en;    // 1
        logic       to_flash;   // 0
    } seq_desc_t;

    localparam int DESC_W      = $bits(seq_desc_t);
    localparam int IDX_W       = 3;
    localparam logic [7:0] STATUS_CMD = 8'h70;
    localparam int STAT_RDY_BIT  = 6;
    localparam int STAT_FAIL_BIT = 0;

    function automatic logic [IDX_W-1:0] acyc_count(input logic [1:0] code);
        logic [IDX_W-1:0] n;
        unique case (code)
            2'd0:    n = 3'd0;
            2'd1:    n = 3'd1;
            2'd2:    n = 3'd3;
            default: n = 3'd5;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/nand_seq_buf.sv
module nand_seq_buf #(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic [7:0]    a_wdata,
    output logic [7:0]    a_rdata,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic [7:0]    b_wdata,
    output logic [7:0]    b_rdata
);

    logic [7:0] mem [DEPTH];

    // sequencer port wins a same-address collision
    always_ff @(posedge clk) begin
        if (a_we && !(b_we && (a_addr == b_addr)))
            mem[a_addr] <= a_wdata;
        if (b_we)
            mem[b_addr] <= b_wdata;
    end

    assign a_rdata = mem[a_addr];
    assign b_rdata = mem[b_addr];

endmodule

// File: rtl/nand_seq_addr.sv
module nand_seq_addr
    import nand_seq_pkg::*;
#(
    parameter int ROW_BYTES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   capture,
    input  logic [7:0]             lo_in,
    input  logic [8*ROW_BYTES-1:0] row_in,
    input  logic                   five,
    input  logic [IDX_W-1:0]       idx,
    output logic [7:0]             byte_o
);

    logic [7:0]             lo_q;
    logic [8*ROW_BYTES-1:0] row_q;
    logic [7:0]             lanes [ROW_BYTES];
    logic [IDX_W-1:0]       lane;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q  <= '0;
            row_q <= '0;
        end else if (capture) begin
            lo_q  <= lo_in;
            row_q <= row_in;
        end
    end

    for (genvar g = 0; g < ROW_BYTES; g++) begin : g_lane
        assign lanes[g] = row_q[8*g +: 8];
    end

    always_comb begin
        lane   = five ? idx - 3'd1 : idx;
        byte_o = 8'h00;
        if (five && (idx == '0)) begin
            byte_o = lo_q;
        end else begin
            for (int k = 0; k < ROW_BYTES; k++)
                if (lane == IDX_W'(k)) byte_o = lanes[k];
        end
    end

endmodule

// File: rtl/nand_seq_fsm.sv
module nand_seq_fsm
    import nand_seq_pkg::*;
#(
    parameter int AW         = 6,
    parameter int LEN_W      = 7,
    parameter int SETTLE_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_valid,
    input  logic [DESC_W-1:0] desc_word,
    input  logic [LEN_W-1:0]  xfer_len,
    output logic              accept,
    output logic              addr_five,
    output logic [IDX_W-1:0]  addr_idx,
    input  logic [7:0]        addr_byte,
    output logic [AW-1:0]     buf_addr,
    output logic              buf_we,
    output logic [7:0]        buf_wdata,
    input  logic [7:0]        buf_rdata,
    output logic              nd_ce_n,
    output logic              nd_cle,
    output logic              nd_ale,
    output logic              nd_we_n,
    output logic              nd_re_n,
    output logic [7:0]        nd_dq_o,
    output logic              nd_dq_oe,
    input  logic [7:0]        nd_dq_i,
    input  logic              nd_rb,
    output logic              busy,
    output logic              done,
    output logic [7:0]        stat_byte,
    output logic              stat_ok
);

    localparam int SET_W  = $clog2(SETTLE_CYC + 1);
    localparam int MAX_LS = (LEN_W > SET_W) ? LEN_W : SET_W;
    localparam int CNT_W  = (MAX_LS > IDX_W) ? MAX_LS : IDX_W;

    seq_state_e       state_q, state_d;
    logic             ph_q, ph_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    seq_desc_t        desc_q;
    logic [LEN_W-1:0] len_q;
    logic [7:0]       stat_q;
    logic             ok_q;

    logic             want_wr, want_rd;
    logic [IDX_W-1:0] ncyc;
    logic             last_addr, last_byte, settle_end;
    seq_state_e       nx_cmd1, nx_addr, nx_wdata, nx_wait, nx_rdata;

    assign accept     = (state_q == ST_IDLE) && desc_valid;
    assign ncyc       = acyc_count(desc_q.acyc);
    assign want_wr    = desc_q.data_en &&  desc_q.to_flash && (len_q != '0);
    assign want_rd    = desc_q.data_en && !desc_q.to_flash && (len_q != '0);
    assign last_addr  = (cnt_q == CNT_W'(ncyc) - CNT_W'(1));
    assign last_byte  = (cnt_q == CNT_W'(len_q) - CNT_W'(1));
    assign settle_end = (cnt_q == CNT_W'(SETTLE_CYC - 1));

    // phase skipping chain
    assign nx_rdata = desc_q.stat_chk ? ST_STCMD : ST_DONE;
    assign nx_wait  = want_rd ? ST_RDATA : nx_rdata;
    assign nx_wdata = desc_q.cmd2_en ? ST_CMD2 : ST_SETTLE;
    assign nx_addr  = want_wr ? ST_WDATA : nx_wdata;
    assign nx_cmd1  = (ncyc != '0) ? ST_ADDR : nx_addr;

    // next-state logic
    always_comb begin
        state_d = state_q;
        ph_d    = ph_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (desc_valid) begin
                    state_d = ST_CMD1;
                    ph_d    = 1'b0;
                    cnt_d   = '0;
                end
            end
            ST_CMD1: begin
                ph_d = ~ph_q;
                if (ph_q) begin state_d = nx_cmd1; cnt_d = '0; end
            end
            ST_ADDR: begin
                ph_d = ~ph_q;
                if (ph_q) begin
                    if (last_addr) begin state_d = nx_addr; cnt_d = '0; end
                    else cnt_d = cnt_q + 1'b1;
                end
            end
            ST_WDATA: begin
                ph_d = ~ph_q;
                if (ph_q) begin
                    if (last_byte) begin state_d = nx_wdata; cnt_d = '0; end
                    else cnt_d = cnt_q + 1'b1;
                end
            end
            ST_CMD2: begin
                ph_d = ~ph_q;
                if (ph_q) begin state_d = ST_SETTLE; cnt_d = '0; end
            end
            ST_SETTLE: begin
                if (settle_end) begin state_d = ST_WAIT; cnt_d = '0; end
                else cnt_d = cnt_q + 1'b1;
            end
            ST_WAIT: begin
                if (nd_rb) begin state_d = nx_wait; cnt_d = '0; ph_d = 1'b0; end
            end
            ST_RDATA: begin
                ph_d = ~ph_q;
                if (ph_q) begin
                    if (last_byte) begin state_d = nx_rdata; cnt_d = '0; end
                    else cnt_d = cnt_q + 1'b1;
                end
            end
            ST_STCMD: begin
                ph_d = ~ph_q;
                if (ph_q) state_d = ST_STREAD;
            end
            ST_STREAD: begin
                ph_d = ~ph_q;
                if (ph_q) state_d = ST_DONE;
            end
            ST_DONE: begin
                state_d = ST_IDLE;
                ph_d    = 1'b0;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ph_q    <= 1'b0;
            cnt_q   <= '0;
            desc_q  <= '0;
            len_q   <= '0;
            stat_q  <= '0;
            ok_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            ph_q    <= ph_d;
            cnt_q   <= cnt_d;
            if (accept) begin
                desc_q <= seq_desc_t'(desc_word);
                len_q  <= xfer_len;
                ok_q   <= 1'b0;
            end
            if ((state_q == ST_STREAD) && !ph_q) begin
                stat_q <= nd_dq_i;
                ok_q   <= nd_dq_i[STAT_RDY_BIT] && !nd_dq_i[STAT_FAIL_BIT];
            end
        end
    end

    // outputs
    always_comb begin
        nd_cle   = 1'b0;
        nd_ale   = 1'b0;
        nd_dq_oe = 1'b0;
        nd_dq_o  = 8'h00;
        buf_we   = 1'b0;
        unique case (state_q)
            ST_CMD1:  begin nd_cle = 1'b1; nd_dq_oe = 1'b1; nd_dq_o = desc_q.cmd1; end
            ST_CMD2:  begin nd_cle = 1'b1; nd_dq_oe = 1'b1; nd_dq_o = desc_q.cmd2; end
            ST_STCMD: begin nd_cle = 1'b1; nd_dq_oe = 1'b1; nd_dq_o = STATUS_CMD; end
            ST_ADDR:  begin nd_ale = 1'b1; nd_dq_oe = 1'b1; nd_dq_o = addr_byte; end
            ST_WDATA: begin nd_dq_oe = 1'b1; nd_dq_o = buf_rdata; end
            ST_RDATA: buf_we = !ph_q;
            default:  ;
        endcase
        nd_ce_n   = (state_q == ST_IDLE);
        nd_we_n   = !(nd_dq_oe && !ph_q);
        nd_re_n   = !(((state_q == ST_RDATA) || (state_q == ST_STREAD)) && !ph_q);
        buf_addr  = cnt_q[AW-1:0];
        buf_wdata = nd_dq_i;
        addr_idx  = cnt_q[IDX_W-1:0];
        addr_five = (desc_q.acyc == 2'd3);
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_DONE);
        stat_byte = stat_q;
        stat_ok   = ok_q;
    end

endmodule

// File: rtl/nand_seq.sv
module nand_seq
    import nand_seq_pkg::*;
#(
    parameter int BUF_DEPTH  = 64,
    parameter int SETTLE_CYC = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         desc_valid,
    input  logic [21:0]                  desc_word,
    input  logic [$clog2(BUF_DEPTH):0]   xfer_len,
    input  logic [7:0]                   addr_lo,
    input  logic [31:0]                  addr_row,
    output logic                         busy,
    output logic                         done,
    output logic [7:0]                   stat_byte,
    output logic                         stat_ok,
    input  logic                         hst_we,
    input  logic [$clog2(BUF_DEPTH)-1:0] hst_addr,
    input  logic [7:0]                   hst_wdata,
    output logic [7:0]                   hst_rdata,
    output logic                         nd_ce_n,
    output logic                         nd_cle,
    output logic                         nd_ale,
    output logic                         nd_we_n,
    output logic                         nd_re_n,
    output logic [7:0]                   nd_dq_o,
    output logic                         nd_dq_oe,
    input  logic [7:0]                   nd_dq_i,
    input  logic                         nd_rb
);

    localparam int AW        = $clog2(BUF_DEPTH);
    localparam int LEN_W     = AW + 1;
    localparam int ROW_BYTES = 4;

    logic             accept, addr_five, buf_we;
    logic [IDX_W-1:0] addr_idx;
    logic [7:0]       addr_byte, buf_wdata, buf_rdata;
    logic [AW-1:0]    buf_addr;

    nand_seq_fsm #(
        .AW(AW), .LEN_W(LEN_W), .SETTLE_CYC(SETTLE_CYC)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .desc_valid(desc_valid), .desc_word(desc_word), .xfer_len(xfer_len),
        .accept(accept), .addr_five(addr_five), .addr_idx(addr_idx),
        .addr_byte(addr_byte),
        .buf_addr(buf_addr), .buf_we(buf_we), .buf_wdata(buf_wdata),
        .buf_rdata(buf_rdata),
        .nd_ce_n(nd_ce_n), .nd_cle(nd_cle), .nd_ale(nd_ale),
        .nd_we_n(nd_we_n), .nd_re_n(nd_re_n),
        .nd_dq_o(nd_dq_o), .nd_dq_oe(nd_dq_oe), .nd_dq_i(nd_dq_i),
        .nd_rb(nd_rb),
        .busy(busy), .done(done), .stat_byte(stat_byte), .stat_ok(stat_ok)
    );

    nand_seq_addr #(.ROW_BYTES(ROW_BYTES)) u_addr (
        .clk(clk), .rst_n(rst_n), .capture(accept),
        .lo_in(addr_lo), .row_in(addr_row),
        .five(addr_five), .idx(addr_idx), .byte_o(addr_byte)
    );

    nand_seq_buf #(.DEPTH(BUF_DEPTH), .AW(AW)) u_buf (
        .clk(clk),
        .a_we(hst_we), .a_addr(hst_addr), .a_wdata(hst_wdata), .a_rdata(hst_rdata),
        .b_we(buf_we), .b_addr(buf_addr), .b_wdata(buf_wdata), .b_rdata(buf_rdata)
    );

endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       nd_ce_n,
    input logic       nd_cle,
    input logic       nd_ale,
    input logic       nd_we_n,
    input logic       nd_re_n,
    input logic [7:0] nd_dq_o,
    input logic       nd_dq_oe,
    input logic       nd_rb
);

    AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(nd_cle && nd_ale)); // R11

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nd_we_n && !nd_re_n)); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (nd_ce_n && nd_we_n && nd_re_n && !nd_dq_oe && !done)); // R1

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy); // R10

    AST_QUIET_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !nd_rb |-> (nd_we_n && nd_re_n)); // R8

    AST_DQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !nd_we_n |=> (nd_dq_oe && $stable(nd_dq_o))); // R2

    AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !nd_re_n |-> !nd_dq_oe); // R6

endmodule

bind nand_seq nand_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
    .nd_ce_n(nd_ce_n), .nd_cle(nd_cle), .nd_ale(nd_ale),
    .nd_we_n(nd_we_n), .nd_re_n(nd_re_n),
    .nd_dq_o(nd_dq_o), .nd_dq_oe(nd_dq_oe), .nd_rb(nd_rb)
);

// File: tb/nand_seq_tb_top.sv
`timescale 1ns/1ps
module nand_seq_tb_top;

    localparam int BUSY_LEN = 8;
    localparam int EV_CMD = 0, EV_ADR = 1, EV_WR = 2, EV_RD = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        desc_valid = 1'b0;
    logic [21:0] desc_word = '0;
    logic [6:0]  xfer_len = '0;
    logic [7:0]  addr_lo = '0;
    logic [31:0] addr_row = '0;
    logic        busy, done, stat_ok;
    logic [7:0]  stat_byte;
    logic        hst_we = 1'b0;
    logic [5:0]  hst_addr = '0;
    logic [7:0]  hst_wdata = '0;
    logic [7:0]  hst_rdata;
    logic        nd_ce_n, nd_cle, nd_ale, nd_we_n, nd_re_n, nd_dq_oe, nd_rb;
    logic [7:0]  nd_dq_o, nd_dq_i;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    nand_seq dut_i (
        .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_word(desc_word),
        .xfer_len(xfer_len), .addr_lo(addr_lo), .addr_row(addr_row),
        .busy(busy), .done(done), .stat_byte(stat_byte), .stat_ok(stat_ok),
        .hst_we(hst_we), .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .nd_ce_n(nd_ce_n), .nd_cle(nd_cle), .nd_ale(nd_ale), .nd_we_n(nd_we_n),
        .nd_re_n(nd_re_n), .nd_dq_o(nd_dq_o), .nd_dq_oe(nd_dq_oe),
        .nd_dq_i(nd_dq_i), .nd_rb(nd_rb)
    );

    // ---------------- flash bus model ----------------
    logic [7:0] rd_src [256];
    int         rd_idx = 0;
    assign nd_dq_i = rd_src[rd_idx[7:0]];
    always @(posedge nd_re_n) rd_idx = rd_idx + 1;

    int  rb_cnt = 0;
    bit  rb_arm = 0;
    assign nd_rb = (rb_cnt == 0);

    int         lg_n = 0;
    int         lg_t  [512];
    logic [7:0] lg_b  [512];
    logic       lg_rb [512];
    int         viol = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (nd_cle && nd_ale) viol = viol + 1;
            if (!nd_we_n && !nd_re_n) viol = viol + 1;
            if (!nd_we_n) begin
                lg_t[lg_n] = nd_cle ? EV_CMD : (nd_ale ? EV_ADR : EV_WR);
                lg_b[lg_n] = nd_dq_o;
                lg_rb[lg_n] = nd_rb;
                lg_n = lg_n + 1;
            end else if (!nd_re_n) begin
                lg_t[lg_n] = EV_RD;
                lg_b[lg_n] = nd_dq_i;
                lg_rb[lg_n] = nd_rb;
                lg_n = lg_n + 1;
            end
            if (rb_cnt > 0) rb_cnt = rb_cnt - 1;
            if (rb_arm) begin rb_cnt = BUSY_LEN; rb_arm = 0; end
            if (!nd_we_n && nd_cle &&
                (nd_dq_o == 8'h30 || nd_dq_o == 8'h10 || nd_dq_o == 8'hD0 || nd_dq_o == 8'hFF))
                rb_arm = 1;
        end
    end

    // ---------------- helpers ----------------
    function automatic logic [21:0] mk(input logic [7:0] c1, input logic [7:0] c2,
                                       input logic c2en, input logic [1:0] ac,
                                       input logic den, input logic tof, input logic sc);
        return {sc, ac, c2en, c2, c1, den, tof};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic expect_ev(input int idx, input int t, input int b, input string req);
        chk(lg_t[idx] == t && lg_b[idx] == b[7:0], req, $sformatf("event %0d", idx),
            lg_t[idx] * 256 + int'(lg_b[idx]), t * 256 + b);
    endtask

    task automatic buf_put(input int a, input logic [7:0] d);
        hst_we = 1'b1; hst_addr = 6'(a); hst_wdata = d;
        @(posedge clk); #1;
        hst_we = 1'b0;
    endtask

    task automatic buf_get(input int a, output logic [7:0] d);
        hst_addr = 6'(a); #1;
        d = hst_rdata;
    endtask

    // launch one descriptor, wait for done; optional second descriptor while busy
    task automatic run(input logic [21:0] w, input int len, input logic [7:0] a0,
                       input logic [31:0] ar, input bit inject, input logic [21:0] w2,
                       output int cycles);
        bit busy_ok = 1;
        int dones = 0;
        desc_word = w; xfer_len = 7'(len); addr_lo = a0; addr_row = ar;
        desc_valid = 1'b1;
        @(posedge clk); #1;
        desc_valid = 1'b0;
        cycles = 0;
        while (!done && cycles < 5000) begin
            if (!busy) busy_ok = 0;
            if (inject && cycles == 3) begin desc_valid = 1'b1; desc_word = w2; end
            else desc_valid = 1'b0;
            @(posedge clk); #1;
            cycles++;
        end
        desc_valid = 1'b0;
        if (done) dones++;
        chk(busy_ok && busy, "R10", "busy held until done", int'(busy_ok), 1);
        @(posedge clk); #1;
        chk(!done && !busy, "R10", "done single pulse then idle", int'(done) * 2 + int'(busy), 0);
        chk(dones == 1, "R10", "done seen", dones, 1);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk(nd_ce_n && !nd_cle && !nd_ale && nd_we_n && nd_re_n && !nd_dq_oe, "R1",
            "bus idle after reset",
            {nd_ce_n, nd_cle, nd_ale, nd_we_n, nd_re_n, nd_dq_oe}, 6'b100110);
        chk(!busy && !done, "R1", "busy/done after reset", int'(busy) * 2 + int'(done), 0);
    endtask

    task automatic t_read_id();
        int b = lg_n; int cyc; logic [7:0] d [4]; logic [31:0] id;
        rd_src[(rd_idx + 0) % 256] = 8'hEC; rd_src[(rd_idx + 1) % 256] = 8'hD3;
        rd_src[(rd_idx + 2) % 256] = 8'h51; rd_src[(rd_idx + 3) % 256] = 8'h95;
        run(mk(8'h90, 8'h00, 0, 2'd1, 1, 0, 0), 4, 8'h5A, 32'h0000_0077, 0, '0, cyc);
        chk(lg_n - b == 6, "R3", "read id event count", lg_n - b, 6);
        expect_ev(b + 0, EV_CMD, 8'h90, "R2");
        expect_ev(b + 1, EV_ADR, 8'h77, "R3");
        expect_ev(b + 2, EV_RD, 8'hEC, "R6");
        for (int k = 0; k < 4; k++) buf_get(k, d[k]);
        id = {d[3], d[2], d[1], d[0]};
        chk(id == 32'h9551_D3EC, "R6", "packed id from buffer", int'(id), 32'h9551_D3EC);
    endtask

    task automatic t_page_read();
        int b = lg_n; int cyc; logic [7:0] d; bit all_ok = 1; bit rb_ok = 1;
        for (int k = 0; k < 8; k++) rd_src[(rd_idx + k) % 256] = 8'hA0 + 8'(k);
        run(mk(8'h00, 8'h30, 1, 2'd3, 1, 0, 0), 8, 8'h12, 32'h4433_2211, 0, '0, cyc);
        chk(lg_n - b == 15, "R4", "page read event count", lg_n - b, 15);
        expect_ev(b + 0, EV_CMD, 8'h00, "R4");
        expect_ev(b + 1, EV_ADR, 8'h12, "R3");
        expect_ev(b + 2, EV_ADR, 8'h11, "R3");
        expect_ev(b + 5, EV_ADR, 8'h44, "R3");
        expect_ev(b + 6, EV_CMD, 8'h30, "R4");
        for (int k = 0; k < 8; k++) begin
            if (lg_t[b + 7 + k] != EV_RD || !lg_rb[b + 7 + k]) rb_ok = 0;
            buf_get(k, d);
            if (d != 8'hA0 + 8'(k)) all_ok = 0;
        end
        chk(rb_ok, "R6", "reads after ready", int'(rb_ok), 1);
        chk(all_ok, "R6", "page bytes in buffer", int'(all_ok), 1);
        chk(cyc >= BUSY_LEN + 2, "R8", "waited out busy", cyc, BUSY_LEN + 2);
    endtask

    task automatic t_program();
        int b; int cyc; bit ok = 1;
        for (int k = 0; k < 6; k++) buf_put(k, 8'h3C ^ 8'(k * 7));
        b = lg_n;
        run(mk(8'h80, 8'h00, 0, 2'd3, 1, 1, 0), 6, 8'h00, 32'h0000_0105, 0, '0, cyc);
        chk(lg_n - b == 12, "R5", "program event count", lg_n - b, 12);
        expect_ev(b + 0, EV_CMD, 8'h80, "R2");
        expect_ev(b + 2, EV_ADR, 8'h05, "R3");
        for (int k = 0; k < 6; k++)
            if (lg_t[b + 6 + k] != EV_WR || lg_b[b + 6 + k] != (8'h3C ^ 8'(k * 7))) ok = 0;
        chk(ok, "R5", "write bytes in order", int'(ok), 1);
        b = lg_n;
        rd_src[rd_idx % 256] = 8'h40;
        run(mk(8'h10, 8'h00, 0, 2'd0, 0, 0, 1), 0, 8'h00, 32'h0, 0, '0, cyc);
        chk(lg_n - b == 3, "R9", "confirm+status event count", lg_n - b, 3);
        expect_ev(b + 0, EV_CMD, 8'h10, "R4");
        expect_ev(b + 1, EV_CMD, 8'h70, "R9");
        chk(lg_t[b + 2] == EV_RD && lg_rb[b + 2], "R9", "status read after ready",
            lg_t[b + 2], EV_RD);
        chk(stat_ok && stat_byte == 8'h40, "R9", "status 0x40 ok",
            int'(stat_ok) * 256 + int'(stat_byte), 256 + 8'h40);
    endtask

    task automatic t_erase();
        int b = lg_n; int cyc;
        rd_src[rd_idx % 256] = 8'h41;
        run(mk(8'h60, 8'hD0, 1, 2'd2, 0, 0, 1), 0, 8'h99, 32'h00AB_CDEF, 0, '0, cyc);
        chk(lg_n - b == 7, "R3", "erase event count", lg_n - b, 7);
        expect_ev(b + 1, EV_ADR, 8'hEF, "R3");
        expect_ev(b + 3, EV_ADR, 8'hAB, "R3");
        expect_ev(b + 4, EV_CMD, 8'hD0, "R4");
        expect_ev(b + 5, EV_CMD, 8'h70, "R9");
        chk(!stat_ok && stat_byte == 8'h41, "R9", "fail bit clears ok",
            int'(stat_ok) * 256 + int'(stat_byte), 8'h41);
    endtask

    task automatic t_reset_cmd();
        int b = lg_n; int cyc;
        rd_src[rd_idx % 256] = 8'h00;
        run(mk(8'hFF, 8'h00, 0, 2'd0, 0, 0, 1), 0, 8'h00, 32'h0, 0, '0, cyc);
        chk(lg_n - b == 3, "R8", "reset event count", lg_n - b, 3);
        expect_ev(b + 0, EV_CMD, 8'hFF, "R2");
        chk(cyc >= BUSY_LEN + 2, "R8", "reset waits for ready", cyc, BUSY_LEN + 2);
        chk(!stat_ok, "R9", "not-ready status", int'(stat_ok), 0);
    endtask

    task automatic t_small_read();
        int b = lg_n; int cyc;
        for (int k = 0; k < 3; k++) rd_src[(rd_idx + k) % 256] = 8'h60 + 8'(k);
        run(mk(8'h00, 8'h30, 0, 2'd3, 1, 0, 0), 3, 8'h01, 32'h0, 0, '0, cyc);
        chk(lg_n - b == 9, "R2", "no confirm when disabled", lg_n - b, 9);
        expect_ev(b + 6, EV_RD, 8'h60, "R2");
    endtask

    task automatic t_no_data();
        int b; int cyc; bit ok = 1; logic [7:0] d;
        for (int k = 0; k < 5; k++) buf_put(k, 8'h11 * 8'(k + 1));
        b = lg_n;
        run(mk(8'h00, 8'h30, 1, 2'd3, 0, 0, 0), 5, 8'h00, 32'h0, 0, '0, cyc);
        chk(lg_n - b == 7, "R7", "no data strobes", lg_n - b, 7);
        for (int k = 0; k < 5; k++) begin
            buf_get(k, d);
            if (d != 8'h11 * 8'(k + 1)) ok = 0;
        end
        chk(ok, "R7", "buffer untouched", int'(ok), 1);
    endtask

    task automatic t_ignore();
        int b = lg_n; int cyc;
        run(mk(8'h60, 8'hD0, 1, 2'd2, 0, 0, 0), 0, 8'h00, 32'h0000_0300, 1,
            mk(8'hFF, 8'h00, 0, 2'd0, 0, 0, 0), cyc);
        repeat (4) @(posedge clk);
        #1;
        chk(lg_n - b == 5, "R10", "descriptor while busy ignored", lg_n - b, 5);
        chk(!busy, "R10", "stays idle", int'(busy), 0);
    endtask

    initial begin
        for (int k = 0; k < 256; k++) rd_src[k] = 8'h00;
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        @(posedge clk); #1;
        t_read_id();
        t_page_read();
        t_program();
        t_erase();
        t_reset_cmd();
        t_small_read();
        t_no_data();
        t_ignore();
        chk(viol == 0, "R11", "latch/strobe exclusivity", viol, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule